// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address after a translation cache miss. It walks a two-level tree: a directory page, whose base the requester supplies with each miss, and a set of second-level pages. Each second-level page is one 4 KB frame holding 1024 four-byte entries. The walker reads the directory entry first. If that entry is marked valid, it reads the leaf entry from the second-level page it names. If the entry is invalid, that part of the table was never allocated, and the walk stops after a single read with a directory fault.

The walker has three ports. A miss port takes a virtual address and a directory base. A memory port issues one read request at a time and takes one response word per request. A result port returns the physical address, the permission field and the dirty flag, or a fault code. The result stays presented until the consumer acknowledges it, and no new miss is taken before then. Translation storage, entry write-back and replacement belong to the surrounding cache.

Top module: `pt_walker`

## Requirements
- R1: After reset, `miss_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The first read of a walk targets `dir_base + VA[31:22]*4`, using the base and address captured when the miss was accepted.
- R3: A directory entry has its valid flag in bit 0 and the second-level page frame number in bits 31:12. When bit 0 is 0, the result carries fault code 1 after exactly one memory read.
- R4: When the directory entry is valid, the second read targets `{frame, 12'b0} + VA[21:12]*4`.
- R5: A leaf entry holds valid in bit 0, present in bit 1, dirty in bit 2, a 9-bit permission field in bits 11:3 and the frame number in bits 31:12. When valid and present are both 1, the result has fault code 0, `res_pa = {frame, VA[11:0]}`, and `res_perm` and `res_dirty` equal to the entry fields.
- R6: A leaf entry with valid or present at 0 gives fault code 2.
- R7: At most one read is in flight. A request holds its valid and address stable until `mem_req_ready`, and no request is raised while a response is awaited or a result is pending.
- R8: `res_valid` and the result fields stay stable until `res_ready`. `miss_ready` stays 0 from the accepted miss until the result is acknowledged, and returns to 1 in the cycle after the acknowledge.
- R9: A walk that passes the directory level issues exactly two memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss accepted on this cycle if valid |
| miss_va | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Physical address of the directory page |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 32 | Physical address, zero on a fault |
| res_perm | output | 9 | Permission field of the leaf entry |
| res_dirty | output | 1 | Dirty flag of the leaf entry |
| res_fault | output | 2 | 0 none, 1 directory fault, 2 page fault |

## Verification
A wrong walk state shows on the memory port within one or two cycles. It appears as a read at the wrong address, a third read, a missing second read, or a request raised while a response is outstanding. A corrupted captured frame or index shows as a wrong second address before any result exists. Faults in the result stage show at the result port as a wrong fault code, a field that changes while held, or `miss_ready` rising early. The sweep crosses many directory and leaf indices with varying memory stalls, so every branch of the walk is taken many times.

// File: rtl/pt_walk_pkg.sv
// Shared types for the page table walker: walk states and fault codes.
package pt_walk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE     = 3'd0,
        WS_DIR_REQ  = 3'd1,
        WS_DIR_WAIT = 3'd2,
        WS_TBL_REQ  = 3'd3,
        WS_TBL_WAIT = 3'd4,
        WS_DONE     = 3'd5
    } walk_state_t;

    localparam logic [1:0] FLT_NONE = 2'd0;
    localparam logic [1:0] FLT_DIR  = 2'd1;
    localparam logic [1:0] FLT_PAGE = 2'd2;

endpackage

// File: rtl/pt_walk_fsm.sv
// Walk sequencer: steps directory read, leaf read and result hand-off.
// Assumes one response per accepted request, arriving after the request.
// Responses outside the wait states are ignored.
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    input  logic dir_ok,
    input  logic res_ready,
    output logic miss_ready,
    output logic mem_req_valid,
    output logic sel_tbl_addr,
    output logic res_valid,
    output logic take_miss,
    output logic take_dir,
    output logic take_tbl
);

    walk_state_t state_q, state_d;

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:     if (miss_valid)    state_d = WS_DIR_REQ;
            WS_DIR_REQ:  if (mem_req_ready) state_d = WS_DIR_WAIT;
            WS_DIR_WAIT: if (mem_rsp_valid) state_d = dir_ok ? WS_TBL_REQ : WS_DONE;
            WS_TBL_REQ:  if (mem_req_ready) state_d = WS_TBL_WAIT;
            WS_TBL_WAIT: if (mem_rsp_valid) state_d = WS_DONE;
            WS_DONE:     if (res_ready)     state_d = WS_IDLE;
            default:                        state_d = WS_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Handshake and capture strobes decoded from the state.
    always_comb begin
        miss_ready    = (state_q == WS_IDLE);
        mem_req_valid = (state_q == WS_DIR_REQ) || (state_q == WS_TBL_REQ);
        sel_tbl_addr  = (state_q == WS_TBL_REQ);
        res_valid     = (state_q == WS_DONE);
        take_miss     = miss_ready && miss_valid;
        take_dir      = (state_q == WS_DIR_WAIT) && mem_rsp_valid;
        take_tbl      = (state_q == WS_TBL_WAIT) && mem_rsp_valid;
    end

endmodule

// File: rtl/pt_addr_gen.sv
// Read address generator: directory entry address from the base and the
// upper index, or leaf entry address from the captured frame and the
// middle index. Purely combinational.
module pt_addr_gen #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRY_LOG2 = 2,
    localparam int TBL_IDX_W = PAGE_SHIFT - ENTRY_LOG2,
    localparam int PFN_W     = PA_W - PAGE_SHIFT
) (
    input  logic [VA_W-1:0]  va,
    input  logic [PA_W-1:0]  dir_base,
    input  logic [PFN_W-1:0] tbl_pfn,
    input  logic             sel_tbl,
    output logic [PA_W-1:0]  addr
);

    localparam int DIR_IDX_W = VA_W - PAGE_SHIFT - TBL_IDX_W;

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [TBL_IDX_W-1:0] tbl_idx;
    logic [PA_W-1:0]      dir_addr;
    logic [PA_W-1:0]      tbl_addr;

    // Index split and scaled entry offsets.
    always_comb begin
        dir_idx  = va[VA_W-1 -: DIR_IDX_W];
        tbl_idx  = va[PAGE_SHIFT +: TBL_IDX_W];
        dir_addr = dir_base + (PA_W'(dir_idx) << ENTRY_LOG2);
        tbl_addr = {tbl_pfn, {PAGE_SHIFT{1'b0}}} + (PA_W'(tbl_idx) << ENTRY_LOG2);
        addr     = sel_tbl ? tbl_addr : dir_addr;
    end

endmodule

// File: rtl/pt_entry_decode.sv
// Table entry field decoder. Directory and leaf entries share one layout:
// bit 0 valid, bit 1 present, bit 2 dirty, bits PAGE_SHIFT-1:3 permission,
// top bits frame number. Directory use takes only valid and frame.
module pt_entry_decode #(
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRY_LOG2 = 2,
    localparam int ENTRY_W   = 8 << ENTRY_LOG2,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int PERM_W    = PAGE_SHIFT - 3
) (
    input  logic [ENTRY_W-1:0] word,
    output logic               valid,
    output logic               present,
    output logic               dirty,
    output logic [PERM_W-1:0]  perm,
    output logic [PFN_W-1:0]   pfn
);

    // Field extraction.
    always_comb begin
        valid   = word[0];
        present = word[1];
        dirty   = word[2];
        perm    = word[3 +: PERM_W];
        pfn     = word[ENTRY_W-1 -: PFN_W];
    end

endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top. Captures the miss, issues the directory
// read and, if that entry is valid, the leaf read, then holds the result
// until acknowledged. Assumes the memory returns one word per request.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRY_LOG2 = 2,
    localparam int ENTRY_W   = 8 << ENTRY_LOG2,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int PERM_W    = PAGE_SHIFT - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [VA_W-1:0]    miss_va,
    input  logic [PA_W-1:0]    dir_base,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [PA_W-1:0]    res_pa,
    output logic [PERM_W-1:0]  res_perm,
    output logic               res_dirty,
    output logic [1:0]         res_fault
);

    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   base_q;
    logic [PFN_W-1:0]  tbl_pfn_q;
    logic              sel_tbl, take_miss, take_dir, take_tbl;
    logic              e_valid, e_present, e_dirty;
    logic [PERM_W-1:0] e_perm;
    logic [PFN_W-1:0]  e_pfn;

    pt_walk_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .dir_ok        (e_valid),
        .res_ready     (res_ready),
        .miss_ready    (miss_ready),
        .mem_req_valid (mem_req_valid),
        .sel_tbl_addr  (sel_tbl),
        .res_valid     (res_valid),
        .take_miss     (take_miss),
        .take_dir      (take_dir),
        .take_tbl      (take_tbl)
    );

    pt_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LOG2(ENTRY_LOG2)
    ) i_addr (
        .va       (va_q),
        .dir_base (base_q),
        .tbl_pfn  (tbl_pfn_q),
        .sel_tbl  (sel_tbl),
        .addr     (mem_req_addr)
    );

    pt_entry_decode #(
        .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_LOG2(ENTRY_LOG2)
    ) i_dec (
        .word    (mem_rsp_data),
        .valid   (e_valid),
        .present (e_present),
        .dirty   (e_dirty),
        .perm    (e_perm),
        .pfn     (e_pfn)
    );

    // Miss capture: address and directory base held for the whole walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            base_q <= '0;
        end else if (take_miss) begin
            va_q   <= miss_va;
            base_q <= dir_base;
        end
    end

    // Directory capture: frame of the second-level page.
    always_ff @(posedge clk) begin
        if (!rst_n)        tbl_pfn_q <= '0;
        else if (take_dir) tbl_pfn_q <= e_pfn;
    end

    // Result capture: cleared on a new miss, filled by either level.
    always_ff @(posedge clk) begin
        if (!rst_n || take_miss) begin
            res_pa    <= '0;
            res_perm  <= '0;
            res_dirty <= 1'b0;
            res_fault <= FLT_NONE;
        end else if (take_dir && !e_valid) begin
            res_fault <= FLT_DIR;
        end else if (take_tbl) begin
            if (e_valid && e_present) begin
                res_pa    <= {e_pfn, va_q[PAGE_SHIFT-1:0]};
                res_perm  <= e_perm;
                res_dirty <= e_dirty;
                res_fault <= FLT_NONE;
            end else begin
                res_fault <= FLT_PAGE;
            end
        end
    end

endmodule

// File: rtl/pt_walker_checker.sv
// Protocol checker for pt_walker, bound to every instance. Counts reads
// per walk to bound them and to tie a directory fault to one read.
module pt_walker_checker
    import pt_walk_pkg::*;
#(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            res_valid,
    input logic            res_ready,
    input logic [PA_W-1:0] res_pa,
    input logic [1:0]      res_fault
);

    logic [2:0] rd_cnt;

    // Reads issued since the last accepted miss.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rd_cnt <= '0;
        else if (miss_valid && miss_ready) rd_cnt <= '0;
        else if (mem_req_valid && mem_req_ready && rd_cnt != 3'd7)
            rd_cnt <= rd_cnt + 3'd1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
    AST_NO_REQ_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_req_valid); // R7
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault)); // R8
    AST_BUSY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !miss_ready); // R8
    AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 3'd2); // R9
    AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault == FLT_DIR |-> rd_cnt == 3'd1); // R3
    AST_PAGE_RESULT_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault != FLT_DIR |-> rd_cnt == 3'd2); // R9
    AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_fault != 2'd3); // R6

endmodule

bind pt_walker pt_walker_checker #(.PA_W(PA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_pa        (res_pa),
    .res_fault     (res_fault)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
// Sweep of directory and leaf indices against an arithmetic table model.
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_va = '0;
    logic [31:0] dir_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_pa;
    logic [8:0]  res_perm;
    logic        res_dirty;
    logic [1:0]  res_fault;

    int n_tests = 0;
    int n_fail  = 0;
    int reads   = 0;
    int stall_cfg = 0;
    logic [31:0] addr_log [2];
    bit done = 0;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Directory entry model: bit0 valid, bits 31:12 second-level frame.
    function automatic logic [31:0] dir_word(logic [19:0] bpage, logic [9:0] idx);
        logic [19:0] pfn = {1'b1, bpage[8:0], idx};
        return {pfn, 11'b0, 1'((idx % 3) != 0)};
    endfunction

    // Leaf entry model: bit0 valid, bit1 present, bit2 dirty, 11:3 perm.
    function automatic logic [31:0] pte_word(logic [19:0] tpage, logic [9:0] i);
        logic [19:0] pfn  = (tpage ^ 20'h5A5A5) + {10'b0, i};
        logic [8:0]  perm = 9'(i * 7) ^ tpage[8:0];
        return {pfn, perm, i[0], 1'((i % 7) != 0), 1'((i % 5) != 0)};
    endfunction

    function automatic logic [31:0] mem_read(logic [31:0] a);
        if (a[31]) return pte_word(a[31:12], a[11:2]);
        return dir_word(a[31:12], a[11:2]);
    endfunction

    // Memory responder: one read in flight, optional ready stalls.
    task automatic mem_server();
        bit pend = 0;
        bit was_stalled = 0;
        logic [31:0] hold, stalled_addr;
        int stall_ctr = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (was_stalled)
                chk(mem_req_valid && mem_req_addr == stalled_addr, "R7",
                    "stalled request changed", mem_req_addr, stalled_addr);
            was_stalled = 0;
            if (pend) begin
                chk(!mem_req_valid, "R7", "request while response due",
                    32'(mem_req_valid), 32'd0);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = hold;
                pend = 0;
            end
            mem_req_ready = (stall_ctr == 0);
            if (mem_req_valid && mem_req_ready) begin
                if (reads < 2) addr_log[reads] = mem_req_addr;
                reads++;
                hold = mem_read(mem_req_addr);
                pend = 1;
            end else if (mem_req_valid) begin
                was_stalled = 1;
                stalled_addr = mem_req_addr;
            end
            stall_ctr = (stall_ctr == 0) ? stall_cfg : stall_ctr - 1;
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base);
        logic [9:0]  didx = va[31:22];
        logic [9:0]  tidx = va[21:12];
        logic [31:0] d = dir_word(base[31:12], didx);
        logic [31:0] p = pte_word(d[31:12], tidx);
        logic [31:0] pa0, perm0, flt0;
        int t = 0;
        @(negedge clk);
        reads = 0;
        miss_va = va; dir_base = base; miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0; miss_va = '1; dir_base = '1;
        chk(!miss_ready, "R8", "busy after accept", 32'(miss_ready), 32'd0);
        while (!res_valid && t < 200) begin @(negedge clk); t++; end
        chk(res_valid, "R8", "walk timeout", 32'(res_valid), 32'd1);
        chk(addr_log[0] == base + {20'b0, didx, 2'b0}, "R2", "directory address",
            addr_log[0], base + {20'b0, didx, 2'b0});
        if (!d[0]) begin
            chk(res_fault == 2'd1, "R3", "directory fault code", 32'(res_fault), 32'd1);
            chk(reads == 1, "R3", "reads on directory fault", 32'(reads), 32'd1);
        end else begin
            chk(reads == 2, "R9", "reads on full walk", 32'(reads), 32'd2);
            chk(addr_log[1] == {d[31:12], 12'b0} + {20'b0, tidx, 2'b0}, "R4",
                "leaf address", addr_log[1], {d[31:12], 12'b0} + {20'b0, tidx, 2'b0});
            if (!(p[0] && p[1])) begin
                chk(res_fault == 2'd2, "R6", "page fault code", 32'(res_fault), 32'd2);
            end else begin
                chk(res_fault == 2'd0, "R5", "no fault", 32'(res_fault), 32'd0);
                chk(res_pa == {p[31:12], va[11:0]}, "R5", "physical address",
                    res_pa, {p[31:12], va[11:0]});
                chk(res_perm == p[11:3], "R5", "permission", 32'(res_perm), 32'(p[11:3]));
                chk(res_dirty == p[2], "R5", "dirty", 32'(res_dirty), 32'(p[2]));
            end
        end
        pa0 = res_pa; perm0 = 32'(res_perm); flt0 = 32'(res_fault);
        repeat (2) @(negedge clk);
        chk(res_valid && res_pa == pa0 && 32'(res_fault) == flt0 && 32'(res_perm) == perm0,
            "R8", "result held", res_pa, pa0);
        chk(!miss_ready && !mem_req_valid, "R8", "idle while holding",
            32'({miss_ready, mem_req_valid}), 32'd0);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid && miss_ready, "R8", "release after ack",
            32'({res_valid, miss_ready}), 32'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(miss_ready && !mem_req_valid && !res_valid, "R1", "reset state",
            32'({miss_ready, mem_req_valid, res_valid}), 32'b100);
        fork mem_server(); join_none
        for (int di = 0; di < 15; di++) begin
            for (int ti = 0; ti < 38; ti++) begin
                logic [9:0] dv = (di < 12) ? 10'(di) : 10'(1009 + di);
                logic [9:0] tv = (ti < 36) ? 10'(ti) : 10'(986 + ti);
                logic [11:0] off = 12'(di * 37 + ti * 11);
                stall_cfg = (di + ti) % 3;
                walk({dv, tv, off}, ((di + ti) % 2 == 0) ? 32'h0000_1000 : 32'h0000_3000);
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule